// File: doc/BRIEF.md
# Receive Sample-Point Tuner

This block finds a working sample point for the receive clock of a card interface. It runs in two stages. First it steps through the four coarse clock phases in ascending order. For each phase it asks an external engine to perform a test read and compare the data. The set of phases that pass is matched against a fixed table of cases. Each case either settles on one phase, or settles on a base phase and then calls for a fine sweep of the delay line. An unrecognised pass set ends the run with an error.

In the fine stage the block walks the delay taps from zero upward. The step size is derived from the ratio between a 150 MHz reference and the bus clock. Every tap that passes is recorded, and the middle entry of that list is applied. When only a single tap passes, the step is halved and the sweep starts again from tap zero.

The surrounding logic starts a run with a pulse. It supplies the clock ratio and a per-test timeout, and it answers each test request with a result strobe. Tuning ends with a one-cycle done or error pulse, and the chosen settings are then held on the phase and delay outputs.

Top module: `rx_sample_tuner`

## Requirements
- R1: During and after reset, busy_o, done_o, err_o and test_req_o are 0, and phase_o, delay_o and dly_sel_o are 0.
- R2: A start_i pulse seen while idle raises busy_o in the next cycle, sets dly_sel_o to 1 (phase plus delay line) and loads delay_o with 0. A start_i seen while a run is in progress has no effect on the sequence of tests.
- R3: Each test is one cycle of test_req_o while phase_o and delay_o carry the setting under test. The phase code is 0=0°, 1=90°, 2=180°, 3=270°. The coarse stage tests codes 0,1,2,3 in that order with delay_o held at 0.
- R4: A test passes only if res_valid_i is high with res_pass_i high in one of the timeout_i cycles that follow the request cycle. A strobe in the last of those cycles is accepted. With no strobe the test fails, and a timeout of 0 acts as 1. A strobe outside the waiting window is ignored.
- R5: With passing phases listed in ascending order, the fixed cases are: list starts 0°,90°,180° gives 90°; list starts 90°,180°,270° gives 180°; list starts 0°,180° gives 0°. These three finish with delay_o 0 and no fine sweep.
- R6: These cases apply a base phase and then run the fine sweep: exactly 0°,90° gives 0°; exactly 90°,180° gives 90°; list starts 180°,270° gives 180°; exactly 180° gives 90°; exactly 90° gives 0°; list starts 270° gives 180°. The cases are checked in the order of R5 and then R6.
- R7: Any other pass set (including none) ends the run with err_o and no fine test.
- R8: The initial fine step is 15 × max(clk_ratio_i,1), limited to 255. The taps tested are 0, step, 2·step, and so on, for every value up to 255.
- R9: When two or more taps pass, delay_o takes the passing tap at 0-based index floor(count/2) in the order found, and done_o pulses.
- R10: When exactly one tap passes, the step is halved (rounded down) and the sweep restarts at tap 0. If the step was already 1, or if no tap passes, err_o pulses.
- R11: done_o and err_o are one-cycle pulses and never coincide, and busy_o is 0 in that cycle. busy_o stays 1 from the cycle after an accepted start until that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse |
| clk_ratio_i | input | RATIO_W | Rounded-up ratio of 150 MHz to the bus clock |
| timeout_i | input | TMO_W | Cycles to wait for a test result |
| test_req_o | output | 1 | One-cycle request for a test read at the current setting |
| res_valid_i | input | 1 | Test result strobe |
| res_pass_i | input | 1 | Test result, 1 = data matched |
| phase_o | output | 2 | Coarse phase code under test or applied |
| delay_o | output | TAP_W | Delay tap under test or applied |
| dly_sel_o | output | 1 | 1 selects the phase-plus-delay-line clock |
| busy_o | output | 1 | Tuning in progress |
| done_o | output | 1 | One-cycle pulse, settings applied |
| err_o | output | 1 | One-cycle pulse, tuning failed |

## Verification
The result strobe and the expiry of the timeout can fall in the same cycle. The block then treats the strobe as a real result, not as a timeout. The bench provokes this by answering every request exactly timeout_i cycles later, and separately with a timeout of 0 and a one-cycle answer. The pass-driven phase choice must then match the model. The bench also answers one cycle too late. That strobe then lands on the next request cycle, and the run must end in error without any setting having passed.

// File: rtl/tuner_pkg.sv
package tuner_pkg;

    localparam int NUM_PHASES = 4;
    localparam logic [2:0] PH_NONE = 3'd4;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PH_REQ,
        ST_PH_WAIT,
        ST_PH_PICK,
        ST_DL_REQ,
        ST_DL_WAIT,
        ST_DL_PICK,
        ST_DONE,
        ST_FAIL
    } tune_state_e;

    typedef struct packed {
        logic       valid;
        logic [1:0] phase;
        logic       sweep;
    } phase_choice_t;

    // Map the ascending list of passing coarse phases to a decision.
    function automatic phase_choice_t choose_phase(input logic [NUM_PHASES-1:0] mask);
        logic [2:0][2:0] lst;
        int              n;
        phase_choice_t   r;
        lst = {3{PH_NONE}};
        n   = 0;
        for (int i = 0; i < NUM_PHASES; i++) begin
            if (mask[i]) begin
                if (n < 3) lst[n[1:0]] = 3'(i);
                n++;
            end
        end
        r = '{valid: 1'b1, phase: 2'd0, sweep: 1'b0};
        if (lst[0] == 3'd0 && lst[1] == 3'd1 && lst[2] == 3'd2)
            r.phase = 2'd1;
        else if (lst[0] == 3'd1 && lst[1] == 3'd2 && lst[2] == 3'd3)
            r.phase = 2'd2;
        else if (lst[0] == 3'd0 && lst[1] == 3'd1 && lst[2] == PH_NONE)
            r = '{valid: 1'b1, phase: 2'd0, sweep: 1'b1};
        else if (lst[0] == 3'd0 && lst[1] == 3'd2)
            r.phase = 2'd0;
        else if (lst[0] == 3'd1 && lst[1] == 3'd2 && lst[2] == PH_NONE)
            r = '{valid: 1'b1, phase: 2'd1, sweep: 1'b1};
        else if (lst[0] == 3'd2 && lst[1] == 3'd3)
            r = '{valid: 1'b1, phase: 2'd2, sweep: 1'b1};
        else if (lst[0] == 3'd2 && lst[1] == PH_NONE)
            r = '{valid: 1'b1, phase: 2'd1, sweep: 1'b1};
        else if (lst[0] == 3'd1 && lst[1] == PH_NONE)
            r = '{valid: 1'b1, phase: 2'd0, sweep: 1'b1};
        else if (lst[0] == 3'd3)
            r = '{valid: 1'b1, phase: 2'd2, sweep: 1'b1};
        else
            r.valid = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/tune_step_gen.sv
module tune_step_gen #(
    parameter int RATIO_W   = 8,
    parameter int TAP_W     = 8,
    parameter int STEP_UNIT = 15
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load_i,
    input  logic [RATIO_W-1:0] ratio_i,
    input  logic               halve_i,
    output logic [TAP_W-1:0]   step_o,
    output logic               at_min_o
);
    localparam int PROD_W  = RATIO_W + $clog2(STEP_UNIT + 1);
    localparam int TAP_MAX = (1 << TAP_W) - 1;

    logic [RATIO_W-1:0] eff_ratio;
    logic [PROD_W-1:0]  prod;
    logic [TAP_W-1:0]   seed;
    logic [TAP_W-1:0]   step_q;

    always_comb begin
        eff_ratio = (ratio_i == '0) ? RATIO_W'(1) : ratio_i;
        prod      = PROD_W'(STEP_UNIT) * PROD_W'(eff_ratio);
        seed      = (prod > PROD_W'(TAP_MAX)) ? TAP_W'(TAP_MAX) : prod[TAP_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)
            step_q <= TAP_W'(1);
        else if (load_i)
            step_q <= seed;
        else if (halve_i)
            step_q <= step_q >> 1;
    end

    assign step_o   = step_q;
    assign at_min_o = (step_q <= TAP_W'(1));
endmodule

// File: rtl/tune_probe_timer.sv
module tune_probe_timer #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             arm_i,
    input  logic             active_i,
    input  logic [TMO_W-1:0] tmo_i,
    input  logic             res_valid_i,
    input  logic             res_pass_i,
    output logic             finish_o,
    output logic             pass_o
);
    logic [TMO_W-1:0] cnt_q;
    logic [TMO_W:0]   cnt_next;
    logic             expire;

    always_comb begin
        cnt_next = {1'b0, cnt_q} + (TMO_W+1)'(1);
        expire   = (cnt_next >= {1'b0, tmo_i});
        finish_o = active_i && (res_valid_i || expire);
        pass_o   = active_i && res_valid_i && res_pass_i;
    end

    always_ff @(posedge clk) begin
        if (rst || arm_i)
            cnt_q <= '0;
        else if (active_i && !finish_o)
            cnt_q <= cnt_next[TMO_W-1:0];
    end
endmodule

// File: rtl/tune_tap_store.sv
module tune_tap_store #(
    parameter int TAP_W = 8,
    parameter int DEPTH = 256
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       clear_i,
    input  logic                       push_i,
    input  logic [TAP_W-1:0]           tap_i,
    output logic [$clog2(DEPTH+1)-1:0] count_o,
    output logic [TAP_W-1:0]           mid_tap_o
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int IDX_W = $clog2(DEPTH);

    logic [TAP_W-1:0] mem [DEPTH];
    logic [CNT_W-1:0] count_q;
    logic             room;

    assign room = (count_q < CNT_W'(DEPTH));

    always_ff @(posedge clk) begin
        if (rst || clear_i)
            count_q <= '0;
        else if (push_i && room)
            count_q <= count_q + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (push_i && room && !clear_i)
            mem[count_q[IDX_W-1:0]] <= tap_i;
    end

    logic [CNT_W-1:0] half;
    assign half      = count_q >> 1;
    assign mid_tap_o = mem[half[IDX_W-1:0]];
    assign count_o   = count_q;
endmodule

// File: rtl/rx_sample_tuner.sv
module rx_sample_tuner
    import tuner_pkg::*;
#(
    parameter int TAP_W     = 8,
    parameter int RATIO_W   = 8,
    parameter int TMO_W     = 16,
    parameter int STEP_UNIT = 15
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  logic [RATIO_W-1:0] clk_ratio_i,
    input  logic [TMO_W-1:0]   timeout_i,
    output logic               test_req_o,
    input  logic               res_valid_i,
    input  logic               res_pass_i,
    output logic [1:0]         phase_o,
    output logic [TAP_W-1:0]   delay_o,
    output logic               dly_sel_o,
    output logic               busy_o,
    output logic               done_o,
    output logic               err_o
);
    localparam int TAP_MAX = (1 << TAP_W) - 1;
    localparam int DEPTH   = TAP_MAX + 1;
    localparam int CNT_W   = $clog2(DEPTH + 1);

    tune_state_e            state_q;
    logic [1:0]             phase_q;
    logic [TAP_W-1:0]       delay_q;
    logic                   sel_q;
    logic [NUM_PHASES-1:0]  mask_q;
    logic [TAP_W:0]         tap_q;
    logic [TAP_W:0]         tap_next;

    logic [TAP_W-1:0]       step;
    logic                   step_at_min;
    logic                   probe_fin;
    logic                   probe_pass;
    logic [CNT_W-1:0]       pass_cnt;
    logic [TAP_W-1:0]       mid_tap;
    phase_choice_t          choice;

    logic arm, waiting, step_load, step_halve, store_clear, store_push;

    always_comb begin
        choice      = choose_phase(mask_q);
        tap_next    = tap_q + (TAP_W+1)'(step);
        arm         = (state_q == ST_PH_REQ) || (state_q == ST_DL_REQ);
        waiting     = (state_q == ST_PH_WAIT) || (state_q == ST_DL_WAIT);
        step_load   = (state_q == ST_IDLE) && start_i;
        step_halve  = (state_q == ST_DL_PICK) && (pass_cnt == CNT_W'(1)) && !step_at_min;
        store_clear = (state_q == ST_PH_PICK) || step_halve;
        store_push  = (state_q == ST_DL_WAIT) && probe_fin && probe_pass;
    end

    tune_step_gen #(.RATIO_W(RATIO_W), .TAP_W(TAP_W), .STEP_UNIT(STEP_UNIT)) step_i (
        .clk      (clk),
        .rst      (rst),
        .load_i   (step_load),
        .ratio_i  (clk_ratio_i),
        .halve_i  (step_halve),
        .step_o   (step),
        .at_min_o (step_at_min)
    );

    tune_probe_timer #(.TMO_W(TMO_W)) timer_i (
        .clk         (clk),
        .rst         (rst),
        .arm_i       (arm),
        .active_i    (waiting),
        .tmo_i       (timeout_i),
        .res_valid_i (res_valid_i),
        .res_pass_i  (res_pass_i),
        .finish_o    (probe_fin),
        .pass_o      (probe_pass)
    );

    tune_tap_store #(.TAP_W(TAP_W), .DEPTH(DEPTH)) store_i (
        .clk       (clk),
        .rst       (rst),
        .clear_i   (store_clear),
        .push_i    (store_push),
        .tap_i     (delay_q),
        .count_o   (pass_cnt),
        .mid_tap_o (mid_tap)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            phase_q <= '0;
            delay_q <= '0;
            sel_q   <= 1'b0;
            mask_q  <= '0;
            tap_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        sel_q   <= 1'b1;
                        phase_q <= '0;
                        delay_q <= '0;
                        mask_q  <= '0;
                        state_q <= ST_PH_REQ;
                    end
                end
                ST_PH_REQ:
                    state_q <= ST_PH_WAIT;
                ST_PH_WAIT: begin
                    if (probe_fin) begin
                        if (probe_pass) mask_q[phase_q] <= 1'b1;
                        if (phase_q == 2'(NUM_PHASES - 1)) begin
                            state_q <= ST_PH_PICK;
                        end else begin
                            phase_q <= phase_q + 2'd1;
                            state_q <= ST_PH_REQ;
                        end
                    end
                end
                ST_PH_PICK: begin
                    if (!choice.valid) begin
                        state_q <= ST_FAIL;
                    end else begin
                        phase_q <= choice.phase;
                        tap_q   <= '0;
                        delay_q <= '0;
                        state_q <= choice.sweep ? ST_DL_REQ : ST_DONE;
                    end
                end
                ST_DL_REQ:
                    state_q <= ST_DL_WAIT;
                ST_DL_WAIT: begin
                    if (probe_fin) begin
                        if (tap_next > (TAP_W+1)'(TAP_MAX)) begin
                            state_q <= ST_DL_PICK;
                        end else begin
                            tap_q   <= tap_next;
                            delay_q <= tap_next[TAP_W-1:0];
                            state_q <= ST_DL_REQ;
                        end
                    end
                end
                ST_DL_PICK: begin
                    if (pass_cnt >= CNT_W'(2)) begin
                        delay_q <= mid_tap;
                        state_q <= ST_DONE;
                    end else if (step_halve) begin
                        tap_q   <= '0;
                        delay_q <= '0;
                        state_q <= ST_DL_REQ;
                    end else begin
                        state_q <= ST_FAIL;
                    end
                end
                ST_DONE, ST_FAIL:
                    state_q <= ST_IDLE;
                default:
                    state_q <= ST_IDLE;
            endcase
        end
    end

    assign test_req_o = arm;
    assign phase_o    = phase_q;
    assign delay_o    = delay_q;
    assign dly_sel_o  = sel_q;
    assign done_o     = (state_q == ST_DONE);
    assign err_o      = (state_q == ST_FAIL);
    assign busy_o     = (state_q != ST_IDLE) && !done_o && !err_o;
endmodule

// File: rtl/rx_sample_tuner_chk.sv
module rx_sample_tuner_chk (
    input logic clk,
    input logic rst,
    input logic start_i,
    input logic test_req_o,
    input logic dly_sel_o,
    input logic busy_o,
    input logic done_o,
    input logic err_o
);
    assert_start_busy_R2: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o && !done_o && !err_o) |=> (busy_o && dly_sel_o));

    assert_req_in_run_R3: assert property (@(posedge clk) disable iff (rst)
        test_req_o |-> (busy_o && dly_sel_o));

    assert_req_single_R3: assert property (@(posedge clk) disable iff (rst)
        test_req_o |=> !test_req_o);

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_err_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        err_o |=> !err_o);

    assert_end_not_busy_R11: assert property (@(posedge clk) disable iff (rst)
        (done_o || err_o) |-> !busy_o);

    assert_end_exclusive_R11: assert property (@(posedge clk) disable iff (rst)
        !(done_o && err_o));

    assert_busy_until_end_R11: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !test_req_o) |=> (busy_o || done_o || err_o));
endmodule

bind rx_sample_tuner rx_sample_tuner_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .test_req_o (test_req_o),
    .dly_sel_o  (dly_sel_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .err_o      (err_o)
);

// File: tb/rx_sample_tuner_tb_top.sv
`timescale 1ns/1ps
module rx_sample_tuner_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [7:0]  clk_ratio_i = 8'd1;
    logic [15:0] timeout_i = 16'd8;
    logic        res_valid_i = 1'b0;
    logic        res_pass_i = 1'b0;
    logic        test_req_o, dly_sel_o, busy_o, done_o, err_o;
    logic [1:0]  phase_o;
    logic [7:0]  delay_o;

    rx_sample_tuner dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .clk_ratio_i(clk_ratio_i),
        .timeout_i(timeout_i), .test_req_o(test_req_o), .res_valid_i(res_valid_i),
        .res_pass_i(res_pass_i), .phase_o(phase_o), .delay_o(delay_o),
        .dly_sel_o(dly_sel_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
    );

    always #2 clk = ~clk;

    int    vectors = 0;
    int    fails = 0;
    int    cycles = 0;
    int    lat = 2;
    int    exp_q[$];
    bit    exp_ok;
    int    exp_ph;
    int    exp_dly;
    bit    model_busy = 0;
    bit    finished = 0;
    bit    active = 0;
    int    pend = 0;
    bit    ppass = 0;
    int    head;
    string tag = "";

    task automatic check(input string req, input int act, input int expv);
        vectors++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer than 150000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    // Responder and per-clock comparison against the model.
    always @(negedge clk) begin
        if (active) begin
            res_valid_i = 1'b0;
            if (pend > 0) begin
                pend--;
                if (pend == 0) begin
                    res_valid_i = 1'b1;
                    res_pass_i  = ppass;
                end
            end
            if (test_req_o) begin
                if (exp_q.size() == 0) begin
                    check({tag, " R3 unexpected test request"}, 1, 0);
                end else begin
                    head = exp_q.pop_front();
                    check({tag, " R3 phase_o"}, int'(phase_o), (head >> 8) & 3);
                    check({tag, " R3 delay_o"}, int'(delay_o), head & 255);
                    check({tag, " R2 dly_sel_o"}, int'(dly_sel_o), 1);
                    pend  = lat;
                    ppass = ((head >> 16) & 1) != 0;
                end
            end
            if (model_busy && !done_o && !err_o)
                check({tag, " R11 busy_o during run"}, int'(busy_o), 1);
            if (done_o || err_o) begin
                check({tag, " R11 busy_o at end"}, int'(busy_o), 0);
                check({tag, " R3 tests left"}, exp_q.size(), 0);
                check({tag, " done_o"}, int'(done_o), int'(exp_ok));
                check({tag, " err_o"}, int'(err_o), int'(!exp_ok));
                if (exp_ok) begin
                    check({tag, " phase_o final"}, int'(phase_o), exp_ph);
                    check({tag, " delay_o final"}, int'(delay_o), exp_dly);
                end
                model_busy = 0;
                finished   = 1;
            end
        end
    end

    // Behavioural model: expected test list and outcome.
    task automatic build(input logic [3:0] mask, input int ratio, input int lo,
                         input int hi, input int tmo, input int l);
        int  plist[$];
        int  taps[$];
        int  step;
        bit  sweep;
        bit  ok_res;
        bit  again;
        int  c0, c1, c2;
        exp_q.delete();
        ok_res  = (l <= ((tmo == 0) ? 1 : tmo));
        exp_ok  = 1;
        exp_ph  = 0;
        exp_dly = 0;
        sweep   = 0;
        for (int p = 0; p < 4; p++) begin
            bit pr;
            pr = ok_res && mask[p];
            exp_q.push_back((int'(pr) << 16) | (p << 8));
            if (pr) plist.push_back(p);
        end
        while (plist.size() < 3) plist.push_back(4);
        c0 = plist[0]; c1 = plist[1]; c2 = plist[2];
        if (c0 == 0 && c1 == 1 && c2 == 2)      exp_ph = 1;
        else if (c0 == 1 && c1 == 2 && c2 == 3) exp_ph = 2;
        else if (c0 == 0 && c1 == 1 && c2 == 4) begin exp_ph = 0; sweep = 1; end
        else if (c0 == 0 && c1 == 2)            exp_ph = 0;
        else if (c0 == 1 && c1 == 2 && c2 == 4) begin exp_ph = 1; sweep = 1; end
        else if (c0 == 2 && c1 == 3)            begin exp_ph = 2; sweep = 1; end
        else if (c0 == 2 && c1 == 4)            begin exp_ph = 1; sweep = 1; end
        else if (c0 == 1 && c1 == 4)            begin exp_ph = 0; sweep = 1; end
        else if (c0 == 3)                       begin exp_ph = 2; sweep = 1; end
        else exp_ok = 0;
        if (exp_ok && sweep) begin
            step  = 15 * ((ratio == 0) ? 1 : ratio);
            if (step > 255) step = 255;
            again = 1;
            while (again) begin
                again = 0;
                taps.delete();
                for (int t = 0; t <= 255; t += step) begin
                    bit pr;
                    pr = ok_res && (t >= lo) && (t <= hi);
                    exp_q.push_back((int'(pr) << 16) | (exp_ph << 8) | t);
                    if (pr) taps.push_back(t);
                end
                if (taps.size() >= 2) exp_dly = taps[taps.size() / 2];
                else if (taps.size() == 1 && step > 1) begin step = step / 2; again = 1; end
                else exp_ok = 0;
            end
        end
    endtask

    task automatic run(input string t, input logic [3:0] mask, input int ratio,
                       input int lo, input int hi, input int tmo, input int l,
                       input bit extra_start);
        tag         = t;
        lat         = l;
        timeout_i   = 16'(tmo);
        clk_ratio_i = 8'(ratio);
        build(mask, ratio, lo, hi, tmo, l);
        finished    = 0;
        pend        = 0;
        active      = 1;
        @(negedge clk);
        start_i = 1'b1;
        @(posedge clk);
        #1 model_busy = 1;
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 0; k < 20000 && !finished; k++) begin
            @(negedge clk);
            start_i = (extra_start && (k == 4 || k == 9));
        end
        start_i = 1'b0;
        check({t, " R11 run finished"}, int'(finished), 1);
        repeat (3) @(negedge clk);
        check({t, " R11 idle after end"}, int'(busy_o), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 busy_o", int'(busy_o), 0);
        check("R1 done_o", int'(done_o), 0);
        check("R1 err_o", int'(err_o), 0);
        check("R1 test_req_o", int'(test_req_o), 0);
        check("R1 phase_o", int'(phase_o), 0);
        check("R1 delay_o", int'(delay_o), 0);
        check("R1 dly_sel_o", int'(dly_sel_o), 0);
        rst = 1'b0;
        @(negedge clk);

        run("R5 pass 0,90,180",        4'b0111, 1, 0, 0, 8, 2, 0);
        run("R5 pass 90,180,270",      4'b1110, 1, 0, 0, 8, 2, 0);
        run("R5 pass 0,180",           4'b0101, 1, 0, 0, 8, 1, 0);
        run("R6 R8 R9 pass 0,90",      4'b0011, 1, 30, 120, 8, 2, 0);
        run("R6 R8 ratio zero",        4'b0110, 0, 200, 255, 8, 1, 0);
        run("R6 R9 pass 180",          4'b0100, 2, 100, 200, 8, 3, 0);
        run("R6 R9 pass 90",           4'b0010, 3, 40, 100, 8, 2, 0);
        run("R6 R10 retry 180,270",    4'b1100, 17, 0, 130, 8, 2, 0);
        run("R6 R10 retry 270",        4'b1000, 4, 50, 70, 8, 2, 0);
        run("R7 pass 0,90,270",        4'b1011, 1, 0, 0, 8, 2, 0);
        run("R7 no phase passes",      4'b0000, 1, 0, 0, 8, 2, 0);
        run("R10 single tap to step1", 4'b1000, 20, 0, 0, 8, 1, 0);
        run("R10 no tap passes",       4'b0010, 1, 300, 400, 8, 1, 0);
        run("R4 strobe at expiry",     4'b0111, 1, 0, 0, 3, 3, 0);
        run("R4 timeout zero",         4'b0111, 1, 0, 0, 0, 1, 0);
        run("R4 strobe too late",      4'b0111, 1, 0, 0, 3, 4, 0);
        run("R2 start while busy",     4'b0011, 1, 30, 120, 8, 2, 1);

        active = 0;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule